// File: doc/BRIEF.md
# Process-ID Translation Flush Scanner

This block walks every translation entry held by an instruction-side and a data-side translation buffer and reports each page that belongs to one process. A single-cycle start pulse carries the process identifier to flush. The scanner then reads the entries one at a time through an external read port that takes a unit select, a set number and an index. Each entry that is live, not shared between processes and tagged with the requested identifier produces one page virtual address on a valid/ready output.

The storage itself is outside the block, and so is whatever consumes the page addresses, such as a cache that drops those pages. When every entry has been examined, a done pulse tells the requester that the flush list is complete. One flush runs at a time.

Top module: `tlb_pid_flush_scan`

## Requirements
- R1: Only bits [7:0] of the 32-bit request identifier `req_pid_i` are compared against entries; bits [31:8] have no effect on which pages are emitted.
- R2: One flush issues exactly 128 reads, in the order unit 0 then 1 (outermost), set 0 to 3, index 0 to 15 (innermost), and each entry is read once.
- R3: An entry is selected when its low word has bit 3 (live) set and bit 4 (shared) clear, and bits [7:0] of its high word equal the requested identifier.
- R4: The address emitted for a selected entry is bits [31:13] of its high word followed by 13 zero bits.
- R5: An entry whose low word bit 4 is set is never emitted, whatever identifier its high word holds.
- R6: Read data is taken from the port exactly one cycle after the cycle in which `rd_en_o` is high, and no new read is issued in that following cycle.
- R7: While `page_valid_o` is high and `page_ready_i` is low, `page_valid_o` stays high, `page_addr_o` holds its value and no read is issued.
- R8: A start pulse that arrives while the block is busy is ignored; the current flush continues with its original identifier.
- R9: `done_o` is high for exactly one cycle after the last entry has been handled and its page (if any) accepted; `busy_o` is low in the following cycle.
- R10: After reset the block is idle: `busy_o`, `done_o`, `rd_en_o` and `page_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to begin a flush |
| req_pid_i | input | 32 | Requested process identifier; low 8 bits used |
| busy_o | output | 1 | A flush is in progress |
| done_o | output | 1 | One-cycle pulse when the flush has finished |
| rd_en_o | output | 1 | Read request to the entry storage |
| rd_unit_o | output | 1 | Unit select: 0 instruction side, 1 data side |
| rd_set_o | output | 2 | Set number of the entry read |
| rd_idx_o | output | 4 | Index of the entry read |
| rd_hi_i | input | 32 | High word of the entry, one cycle after the read |
| rd_lo_i | input | 32 | Low word of the entry, one cycle after the read |
| page_valid_o | output | 1 | A page address is offered |
| page_ready_i | input | 1 | Consumer accepts the offered page |
| page_addr_o | output | 32 | Virtual address of the page to drop |

## Verification
A flush accepted at a clock edge issues its first read in the next cycle, and each read's data is judged in the cycle after it, so an entry costs two cycles plus however long its page waits for ready. The bench does not predict absolute cycle numbers for these; it records every read and every accepted page at the falling edge, comparing reads against the expected scan position and accepted pages against a list computed from its own copy of the entries. The done pulse is checked in the cycle it appears against the read and page totals, and the cycle after it is checked for done and busy both low.

// File: rtl/tlb_pid_flush_scan.sv
module tlb_pid_flush_scan #(
  parameter int UNITS      = 2,
  parameter int SETS       = 4,
  parameter int IDXS       = 16,
  parameter int REQ_W      = 32,
  parameter int PID_W      = 8,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int LIVE_BIT   = 3,
  parameter int SHARE_BIT  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [REQ_W-1:0]          req_pid_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      rd_en_o,
  output logic [$clog2(UNITS)-1:0]  rd_unit_o,
  output logic [$clog2(SETS)-1:0]   rd_set_o,
  output logic [$clog2(IDXS)-1:0]   rd_idx_o,
  input  logic [WORD_W-1:0]         rd_hi_i,
  input  logic [WORD_W-1:0]         rd_lo_i,
  output logic                      page_valid_o,
  input  logic                      page_ready_i,
  output logic [WORD_W-1:0]         page_addr_o
);
  localparam int UNIT_W = $clog2(UNITS);
  localparam int SET_W  = $clog2(SETS);
  localparam int IDX_W  = $clog2(IDXS);
  localparam int CNT_W  = UNIT_W + SET_W + IDX_W;
  localparam int TOTAL  = UNITS * SETS * IDXS;
  localparam int VPN_W  = WORD_W - PAGE_SHIFT;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CHECK, S_EMIT, S_DONE} state_t;

  state_t             state_q;
  logic [CNT_W-1:0]   pos_q;
  logic [PID_W-1:0]   pid_q;
  logic [VPN_W-1:0]   vpn_q;
  logic               last_w;
  logic               hit_w;

  assign last_w = (pos_q == CNT_W'(TOTAL - 1));
  assign hit_w  = rd_lo_i[LIVE_BIT] && !rd_lo_i[SHARE_BIT] &&
                  (rd_hi_i[PID_W-1:0] == pid_q);

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign rd_en_o      = (state_q == S_READ);
  assign page_valid_o = (state_q == S_EMIT);
  assign page_addr_o  = {vpn_q, {PAGE_SHIFT{1'b0}}};
  assign rd_idx_o     = pos_q[IDX_W-1:0];
  assign rd_set_o     = pos_q[IDX_W +: SET_W];
  assign rd_unit_o    = pos_q[IDX_W+SET_W +: UNIT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      pid_q   <= '0;
      vpn_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          pid_q   <= req_pid_i[PID_W-1:0];
          pos_q   <= '0;
          state_q <= S_READ;
        end
        S_READ: state_q <= S_CHECK;
        S_CHECK: begin
          if (hit_w) begin
            vpn_q   <= rd_hi_i[WORD_W-1:PAGE_SHIFT];
            state_q <= S_EMIT;
          end else if (last_w) begin
            state_q <= S_DONE;
          end else begin
            pos_q   <= pos_q + 1'b1;
            state_q <= S_READ;
          end
        end
        S_EMIT: if (page_ready_i) begin
          if (last_w) begin
            state_q <= S_DONE;
          end else begin
            pos_q   <= pos_q + 1'b1;
            state_q <= S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

module tlb_pid_flush_scan_chk #(
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_en_o,
  input logic              page_valid_o,
  input logic              page_ready_i,
  input logic [WORD_W-1:0] page_addr_o
);
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_valid_o && !page_ready_i |=> page_valid_o && $stable(page_addr_o));

  p_no_read_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_valid_o |-> !rd_en_o);

  p_read_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o && start_i |=> busy_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_en_o && !page_valid_o && !done_o);

  p_page_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_valid_o |-> page_addr_o[PAGE_SHIFT-1:0] == '0);
endmodule

bind tlb_pid_flush_scan tlb_pid_flush_scan_chk #(
  .WORD_W(WORD_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .rd_en_o(rd_en_o), .page_valid_o(page_valid_o),
  .page_ready_i(page_ready_i), .page_addr_o(page_addr_o)
);

// File: tb/tlb_pid_flush_scan_bench.sv
module tlb_pid_flush_scan_bench;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] req_pid_i = '0;
  logic        busy_o, done_o, rd_en_o, page_valid_o;
  logic        page_ready_i = 1'b1;
  logic [0:0]  rd_unit_o;
  logic [1:0]  rd_set_o;
  logic [3:0]  rd_idx_o;
  logic [31:0] rd_hi_i = '0, rd_lo_i = '0, page_addr_o;

  logic [31:0] tbl_hi [N];
  logic [31:0] tbl_lo [N];
  logic [31:0] exp_addr [N];
  int exp_n, rd_ptr, emit_ptr, n_chk, n_bad, ready_mode;

  always #2 clk = ~clk;

  tlb_pid_flush_scan u_tlb_pid_flush_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_pid_i(req_pid_i),
    .busy_o(busy_o), .done_o(done_o), .rd_en_o(rd_en_o),
    .rd_unit_o(rd_unit_o), .rd_set_o(rd_set_o), .rd_idx_o(rd_idx_o),
    .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i), .page_valid_o(page_valid_o),
    .page_ready_i(page_ready_i), .page_addr_o(page_addr_o));

  // R6: storage answers one cycle after the read request
  always @(posedge clk) if (rd_en_o) begin
    rd_hi_i <= tbl_hi[{rd_unit_o, rd_set_o, rd_idx_o}];
    rd_lo_i <= tbl_lo[{rd_unit_o, rd_set_o, rd_idx_o}];
  end

  always @(posedge clk) begin
    #1;
    page_ready_i = (ready_mode == 0) ? 1'b1 : 1'($urandom % 2);
  end

  function automatic bit selects(input logic [31:0] hi, input logic [31:0] lo,
                                 input logic [31:0] req);
    return lo[3] && !lo[4] && (hi[7:0] == req[7:0]);
  endfunction

  function automatic logic [31:0] page_of(input logic [31:0] hi);
    return {hi[31:13], 13'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read order (R2), accepted pages (R3 R4 R5), completion (R9)
  always @(negedge clk) if (rst_n) begin
    if (rd_en_o) begin
      check({rd_unit_o, rd_set_o, rd_idx_o} == 7'(rd_ptr) && rd_ptr < N,
            "R2 read order", 32'({rd_unit_o, rd_set_o, rd_idx_o}), 32'(rd_ptr));
      rd_ptr++;
    end
    if (page_valid_o && page_ready_i) begin
      if (emit_ptr < exp_n)
        check(page_addr_o == exp_addr[emit_ptr], "R3/R4/R5 page", page_addr_o,
              exp_addr[emit_ptr]);
      else
        check(1'b0, "R5 unexpected page", page_addr_o, 32'hffffffff);
      emit_ptr++;
    end
    if (done_o) begin
      check(emit_ptr == exp_n, "R9 pages at done", 32'(emit_ptr), 32'(exp_n));
      check(rd_ptr == N, "R2 reads at done", 32'(rd_ptr), 32'(N));
    end
  end

  task automatic flush(input logic [31:0] req, input bit poke);
    exp_n = 0;
    for (int i = 0; i < N; i++)
      if (selects(tbl_hi[i], tbl_lo[i], req)) begin
        exp_addr[exp_n] = page_of(tbl_hi[i]);
        exp_n++;
      end
    rd_ptr = 0;
    emit_ptr = 0;
    @(posedge clk); #1;
    req_pid_i = req; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0; req_pid_i = $urandom;
    if (poke) begin
      repeat (37) @(posedge clk);
      #1; start_i = 1'b1; req_pid_i = req ^ 32'h5a;
      @(posedge clk); #1; start_i = 1'b0;
      @(negedge clk);
      check(busy_o == 1'b1, "R8 busy after ignored start", 32'(busy_o), 32'd1);
    end
    for (int t = 0; t < 2000 && !done_o; t++) @(negedge clk);
    check(done_o == 1'b1, "R9 done seen", 32'(done_o), 32'd1);
    @(negedge clk);
    check(!done_o && !busy_o, "R9 done one cycle", {30'b0, done_o, busy_o}, 32'd0);
  endtask

  task automatic fill_random(input logic [7:0] pid);
    for (int i = 0; i < N; i++) begin
      tbl_hi[i] = {$urandom} & 32'hffffe0ff;
      tbl_hi[i][7:0] = ($urandom % 2) ? pid : 8'($urandom);
      tbl_lo[i] = $urandom;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    ready_mode = 0; n_chk = 0; n_bad = 0; exp_n = 0; rd_ptr = 0; emit_ptr = 0;
    for (int i = 0; i < N; i++) begin tbl_hi[i] = '0; tbl_lo[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !rd_en_o && !page_valid_o, "R10 reset idle",
          {28'b0, busy_o, done_o, rd_en_o, page_valid_o}, 32'd0);

    // R3: every entry matches, all 128 pages, distinct addresses
    for (int i = 0; i < N; i++) begin
      tbl_hi[i] = (32'(i) << 13) | 32'h33; tbl_lo[i] = 32'h8;
    end
    flush(32'h33, 1'b0);
    // R5: same entries marked shared emit nothing
    for (int i = 0; i < N; i++) tbl_lo[i] = 32'h18;
    flush(32'h33, 1'b0);
    // R1: upper request bits differ, only the last entry is live
    for (int i = 0; i < N; i++) tbl_lo[i] = (i == N - 1) ? 32'h8 : 32'h0;
    flush(32'hdead_be33, 1'b0);
    // R7: back-pressure with random ready
    ready_mode = 1;
    for (int i = 0; i < N; i++) tbl_lo[i] = 32'h8;
    flush(32'h0000_0133, 1'b0);
    // random tables with and without an ignored start (R8)
    for (int k = 0; k < 6; k++) begin
      logic [7:0] p;
      p = 8'($urandom);
      fill_random(p);
      ready_mode = k % 2;
      flush({24'($urandom), p}, k >= 3);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule